// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a software-supervised watchdog with a small 32-bit register interface. Software stores a reload value, arms the timer through a control word, and keeps the system alive by writing one exact key word to a dedicated restart register. Any other value written to that register does nothing. This guards against runaway code that writes to random addresses.

While enabled, the counter steps down once per tick. The tick is either every system clock or a 1 MHz enable derived from a prescaler. When the counter steps from one to zero, the block issues a one-cycle timeout strobe and then stays at zero until it is restarted. The control word decides which actions the strobe turns into: a reset request, an interrupt and an external request. It also carries a reset-scope field and an alternate-boot selector, which are passed on as levels. A status register records timeouts in sticky bits that are cleared by writing ones. The status register has a separate bit for a timeout that happened while alternate boot was selected.

The usual bring-up sequence has four steps: clear the control word, write the reload value, write the key, then set the enable bit.

Top module: `wdg_timer`

## Requirements
- R1: After synchronous reset every register reads 0 and the outputs `timeout_strobe`, `reset_req`, `irq`, `ext_req`, `boot_secondary` and `reset_scope` are 0.
- R2: Register offsets are as follows. 0x00 returns the current count, read-only. 0x04 holds the reload value, read/write. 0x08 is the restart register and reads 0. 0x0C holds the control byte, read/write, with bits 31:8 reading 0. 0x10 holds the status. Any other offset reads 0.
- R3: A write of exactly 0x00004755 to offset 0x08 loads the count from the reload register at that clock edge. A write of any other value there, including values whose low 16 bits are 0x4755, leaves the count unchanged.
- R4: Control bit 0 set makes the count decrement by one on each tick. With bit 0 clear the count holds its value.
- R5: With control bit 4 clear a tick occurs every clock. With bit 4 set, exactly one tick occurs in every TICKS_PER_US consecutive clocks, so a reload of N expires between (N-1)*TICKS_PER_US+1 and N*TICKS_PER_US clocks after enabling.
- R6: A tick that takes an enabled count from 1 to 0 raises `timeout_strobe` for exactly one cycle, in the cycle the count first reads 0. The count then holds at 0 with no further strobe. An enabled count already at 0, for example after reloading 0, never strobes.
- R7: During the strobe cycle `reset_req`, `irq` and `ext_req` are high exactly when control bits 1, 2 and 3 respectively are set. At all other times they are low.
- R8: `reset_scope` follows control bits 6:5 (00 SoC, 01 full chip, 10 CPU only). `boot_secondary` follows control bit 7.
- R9: Each timeout sets status bit 0. A timeout while control bit 7 is set also sets status bit 1. The bits are sticky and a written 1 clears the matching bit. A timeout in the same cycle as a clear wins over the clear.
- R10: A key write takes priority over a decrement in the same cycle, and it works whether or not the counter is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| timeout_strobe | output | 1 | One-cycle pulse on expiry |
| reset_req | output | 1 | Reset request pulse |
| irq | output | 1 | Interrupt pulse |
| ext_req | output | 1 | External signal request pulse |
| reset_scope | output | 2 | Selected reset scope |
| boot_secondary | output | 1 | Alternate boot image selected |

## Verification
The bench builds the block with TICKS_PER_US set to 4 instead of the default 100. This makes the prescaled tick mode short enough to measure the complete expiry window of a reload, not just a single decrement. CNT_W stays at 32, so the key register and readback paths are exercised at full width. Small reload values then keep every cycle-exact expiry in the per-clock mode within a handful of cycles.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int          DATA_W      = 32;
    localparam logic [31:0] RESTART_KEY = 32'h0000_4755;

    localparam logic [31:0] OFF_COUNT   = 32'h00;
    localparam logic [31:0] OFF_RELOAD  = 32'h04;
    localparam logic [31:0] OFF_RESTART = 32'h08;
    localparam logic [31:0] OFF_CTRL    = 32'h0C;
    localparam logic [31:0] OFF_STATUS  = 32'h10;

    typedef enum logic [1:0] {
        SCOPE_SOC  = 2'b00,
        SCOPE_CHIP = 2'b01,
        SCOPE_CPU  = 2'b10,
        SCOPE_RSVD = 2'b11
    } scope_e;

    // Packed MSB first: bit 7 boot, 6:5 scope, 4 tick select, 3..0 actions/enable
    typedef struct packed {
        logic   boot_sec;
        scope_e scope;
        logic   tick_us;
        logic   ext_en;
        logic   irq_en;
        logic   rst_en;
        logic   enable;
    } ctrl_t;

    typedef struct packed {
        logic alt_boot_hit;
        logic expired;
    } status_t;

    typedef enum logic [2:0] {
        SEL_COUNT,
        SEL_RELOAD,
        SEL_RESTART,
        SEL_CTRL,
        SEL_STATUS,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [31:0] off);
        case (off)
            OFF_COUNT:   return SEL_COUNT;
            OFF_RELOAD:  return SEL_RELOAD;
            OFF_RESTART: return SEL_RESTART;
            OFF_CTRL:    return SEL_CTRL;
            OFF_STATUS:  return SEL_STATUS;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wdg_tick.sv
module wdg_tick #(
    parameter int TICKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_us,
    output logic tick
);
    localparam int PW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;

    logic us_pulse;

    generate
        if (TICKS_PER_US > 1) begin : g_div
            logic [PW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    div_q <= '0;
                end else if (div_q == PW'(TICKS_PER_US - 1)) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
            assign us_pulse = (div_q == PW'(TICKS_PER_US - 1));

            // R5: the divided enable is never high on two clocks in a row
            a_r5_us_pulse_single: assert property (@(posedge clk) disable iff (rst)
                us_pulse |=> !us_pulse);
        end else begin : g_nodiv
            assign us_pulse = 1'b1;
        end
    endgenerate

    assign tick = sel_us ? us_pulse : 1'b1;

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output logic             strobe
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;
    assign step   = enable && tick && !load && (count != '0);
    assign expire = step && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= expire;
            if (load) begin
                count <= load_val;
            end else if (step) begin
                count <= count - ONE;
            end
        end
    end

    // R3/R10: a key write loads the reload value, overriding any decrement
    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));
    // R4: disabled counter holds
    a_r4_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!enable && !load) |=> $stable(count));
    // R6: zero is sticky until a restart
    a_r6_stay_zero: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !load) |=> count == '0);
    // R6: strobe lasts one cycle and coincides with a zero count
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
    a_r6_strobe_at_zero: assert property (@(posedge clk) disable iff (rst)
        strobe |-> count == '0);

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              load,
    output status_t           status
);
    reg_sel_e sel;
    status_t  clr_mask;
    status_t  set_mask;

    assign sel  = decode_offset(32'(bus_addr));
    assign load = bus_wr && (sel == SEL_RESTART) && (bus_wdata == RESTART_KEY);

    assign clr_mask = (bus_wr && sel == SEL_STATUS) ? status_t'(bus_wdata[1:0]) : '0;
    assign set_mask = '{alt_boot_hit: expire && ctrl.boot_sec, expired: expire};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= '0;
            status <= '0;
        end else begin
            if (bus_wr && sel == SEL_CTRL) begin
                ctrl <= ctrl_t'(bus_wdata[7:0]);
            end
            if (bus_wr && sel == SEL_RELOAD) begin
                reload <= bus_wdata[CNT_W-1:0];
            end
            status <= (status & ~clr_mask) | set_mask;
        end
    end

    always_comb begin
        case (sel)
            SEL_COUNT:  bus_rdata = 32'(count);
            SEL_RELOAD: bus_rdata = 32'(reload);
            SEL_CTRL:   bus_rdata = 32'(ctrl);
            SEL_STATUS: bus_rdata = 32'(status);
            default:    bus_rdata = '0;
        endcase
    end

    // R9: an expiry is always recorded, even against a simultaneous clear
    a_r9_expire_recorded: assert property (@(posedge clk) disable iff (rst)
        expire |=> status.expired);
    // R9: recorded bits persist unless a one is written to them
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (status.expired && !(bus_wr && sel == SEL_STATUS && bus_wdata[0])) |=> status.expired);

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int ADDR_W       = 5,
    parameter int CNT_W        = 32,
    parameter int TICKS_PER_US = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              timeout_strobe,
    output logic              reset_req,
    output logic              irq,
    output logic              ext_req,
    output logic [1:0]        reset_scope,
    output logic              boot_secondary
);
    ctrl_t            ctrl;
    status_t          status;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             load;
    logic             tick;
    logic             expire;
    logic             strobe;

    wdg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count),
        .expire    (expire),
        .ctrl      (ctrl),
        .reload    (reload),
        .load      (load),
        .status    (status)
    );

    wdg_tick #(.TICKS_PER_US(TICKS_PER_US)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .sel_us (ctrl.tick_us),
        .tick   (tick)
    );

    wdg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .enable   (ctrl.enable),
        .tick     (tick),
        .load     (load),
        .load_val (reload),
        .count    (count),
        .expire   (expire),
        .strobe   (strobe)
    );

    assign timeout_strobe = strobe;
    assign reset_req      = strobe && ctrl.rst_en;
    assign irq            = strobe && ctrl.irq_en;
    assign ext_req        = strobe && ctrl.ext_en;
    assign reset_scope    = ctrl.scope;
    assign boot_secondary = ctrl.boot_sec;

    // R9/R6: the strobe cycle always finds the expiry recorded in status
    a_r9_strobe_status: assert property (@(posedge clk) disable iff (rst)
        strobe |-> status.expired);

endmodule

// File: tb/wdg_timer_bench.sv
module wdg_timer_bench;
    localparam int ADDR_W = 5;
    localparam int TPU    = 4;
    localparam logic [4:0] A_CNT = 5'h00, A_RLD = 5'h04, A_RST = 5'h08,
                           A_CTL = 5'h0C, A_STS = 5'h10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              timeout_strobe, reset_req, irq, ext_req, boot_secondary;
    logic [1:0]        reset_scope;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wdg_timer #(.ADDR_W(ADDR_W), .CNT_W(32), .TICKS_PER_US(TPU)) u_wdg_timer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .timeout_strobe(timeout_strobe), .reset_req(reset_req), .irq(irq),
        .ext_req(ext_req), .reset_scope(reset_scope), .boot_secondary(boot_secondary)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic pulses_chk(input string req, input logic [3:0] exp);
        chk(req, {28'd0, timeout_strobe, reset_req, irq, ext_req}, {28'd0, exp});
    endtask

    task automatic arm(input logic [31:0] rl, input logic [31:0] ctl);
        wr(A_CTL, 32'h0);
        wr(A_RLD, rl);
        wr(A_RST, 32'h4755);
        wr(A_CTL, ctl);
    endtask

    task automatic t_reset();
        rd_chk("R1 count", A_CNT, 0);
        rd_chk("R1 reload", A_RLD, 0);
        rd_chk("R1 ctrl", A_CTL, 0);
        rd_chk("R1 status", A_STS, 0);
        pulses_chk("R1 pulses", 4'b0000);
        chk("R1 levels", {29'd0, boot_secondary, reset_scope}, 0);
    endtask

    task automatic t_regmap();
        wr(A_CTL, 32'hFFFF_FFFE);
        rd_chk("R2 ctrl readback", A_CTL, 32'h0000_00FE);
        chk("R8 scope 11 boot 1", {29'd0, boot_secondary, reset_scope}, 32'h7);
        wr(A_CTL, 32'h20);
        chk("R8 scope chip boot 0", {29'd0, boot_secondary, reset_scope}, 32'h1);
        wr(A_CTL, 32'h40);
        chk("R8 scope cpu", {30'd0, reset_scope}, 32'h2);
        wr(A_RLD, 32'hDEAD_BEEF);
        rd_chk("R2 reload readback", A_RLD, 32'hDEAD_BEEF);
        rd_chk("R2 restart reads 0", A_RST, 0);
        rd_chk("R2 unmapped reads 0", 5'h14, 0);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_key();
        wr(A_RLD, 32'h1234);
        wr(A_RST, 32'h4754);
        rd_chk("R3 near-miss key ignored", A_CNT, 0);
        wr(A_RST, 32'h0001_4755);
        rd_chk("R3 upper bits spoil key", A_CNT, 0);
        wr(A_RST, 32'h4755);
        rd_chk("R3 R10 key loads while disabled", A_CNT, 32'h1234);
        wr(A_RLD, 32'h99);
        wr(A_RST, 32'hFFFF_4755);
        rd_chk("R3 bad key keeps count", A_CNT, 32'h1234);
    endtask

    task automatic t_fast_expiry();
        arm(5, 32'h0F);
        rd_chk("R4 count after enable", A_CNT, 5);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            rd_chk("R4 R5 per-clock decrement", A_CNT, 5 - k);
            pulses_chk("R6 R7 strobe timing", (k == 5) ? 4'b1111 : 4'b0000);
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            pulses_chk("R6 no repeat strobe", 4'b0000);
            rd_chk("R6 holds zero", A_CNT, 0);
        end
        rd_chk("R9 status after expiry", A_STS, 32'h1);
        wr(A_STS, 32'h1);
        rd_chk("R9 write-one clears", A_STS, 0);
    endtask

    task automatic t_gated_alt_boot();
        arm(2, 32'h85);
        @(negedge clk);
        pulses_chk("R7 before expiry", 4'b0000);
        @(negedge clk);
        pulses_chk("R7 only irq enabled", 4'b1010);
        chk("R8 boot level", {31'd0, boot_secondary}, 1);
        rd_chk("R9 both bits", A_STS, 32'h3);
        wr(A_STS, 32'h1);
        rd_chk("R9 partial clear", A_STS, 32'h2);
        wr(A_STS, 32'h2);
        rd_chk("R9 full clear", A_STS, 0);
    endtask

    task automatic t_stop_and_priority();
        arm(10, 32'h01);
        repeat (3) @(negedge clk);
        rd_chk("R4 counting", A_CNT, 7);
        wr(A_CTL, 32'h0);
        rd_chk("R4 count at disable", A_CNT, 5);
        repeat (5) @(negedge clk);
        rd_chk("R4 disabled holds", A_CNT, 5);
        wr(A_CTL, 32'h01);
        wr(A_RST, 32'h4755);
        rd_chk("R10 key beats decrement", A_CNT, 10);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_zero_reload();
        arm(0, 32'h0F);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            pulses_chk("R6 zero reload never strobes", 4'b0000);
        end
        rd_chk("R6 zero reload status", A_STS, 0);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_prescaled();
        int n;
        arm(3, 32'h11);
        repeat (TPU) @(negedge clk);
        rd_chk("R5 one tick per window", A_CNT, 2);
        n = TPU;
        while (!timeout_strobe && n < 40) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if (n < 2 * TPU + 1 || n > 3 * TPU) begin
            fails++;
            $display("FAIL R5 prescaled expiry: actual %0d clocks expected %0d..%0d",
                     n, 2 * TPU + 1, 3 * TPU);
        end
        wr(A_STS, 32'h3);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_set_beats_clear();
        arm(3, 32'h01);
        @(negedge clk);
        @(negedge clk);
        // the clear write lands on the same edge as the 1->0 step
        bus_wr = 1'b1; bus_addr = A_STS; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 strobe seen", {31'd0, timeout_strobe}, 1);
        rd_chk("R9 set wins over clear", A_STS, 32'h1);
        wr(A_STS, 32'h1);
        wr(A_CTL, 32'h0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_key();
        t_fast_expiry();
        t_gated_alt_boot();
        t_stop_and_priority();
        t_zero_reload();
        t_prescaled();
        t_set_beats_clear();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule